// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Masked Data Access and Pin Interrupts

This block is one general-purpose I/O port of eight pins, reached over a simple single-cycle 32-bit register bus. Each pin is driven from a software output register or handed over to a peripheral. When a pin is under software control, its direction setting decides whether the pin drives. The data register is reached through an address window in which byte-address bits [9:2] act as a per-pin mask. A single store can therefore set some pins and clear others while the remaining pins keep their values. A load through the same window returns only the pins that the mask selects.

Every pin has its own interrupt detector. The detector sees the pin level after a two-flop synchronizer. It can look for levels or for edges, and for one edge polarity or for both. Edge events are held in a raw status bit until a clear write removes them. A masked status applies the per-pin enable to the raw status. The port drives one interrupt line, which is high while any masked status bit is set. Reads come back in the same cycle: the read data is combinational from the address and the register state. A write takes effect at the clock edge on which it is presented.

Register offsets: data window 0x000 to 0x3FC, direction 0x400, detect kind 0x404, both-edge 0x408, polarity 0x40C, enable 0x410, raw status 0x414, masked status 0x418, clear 0x41C, peripheral select 0x420. Every register uses bits [7:0], and bit n belongs to pin n.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads zero. pin_oe, pin_out and irq are 0, so every pin is a software-controlled input and all interrupts are disabled.
- R2: A write to the data window with byte address bits [9:2] = m changes only the output bits set in m, to the written value. The other output bits keep their values.
- R3: A read from the data window with mask m returns the pin values ANDed with m, and zeros elsewhere. A pin that is a software-controlled output (direction 1, select 0) returns its output register. Any other pin returns its synchronized input level.
- R4: Direction bit 1 makes a software-controlled pin drive (pin_oe=1) with its output register. Direction bit 0 makes it an input.
- R5: Peripheral select bit 1 drives pin_out and pin_oe from alt_out and alt_oe for that pin. Bit 0 leaves the pin under software control.
- R6: In edge mode (detect kind 0) with both-edge 0, polarity 1 latches raw status on a rising input and polarity 0 latches it on a falling input. The opposite edge sets nothing, and the latched bit persists.
- R7: With both-edge 1 in edge mode, a rising edge and a falling edge each latch raw status.
- R8: In level mode (detect kind 1), raw status is 1 exactly while the synchronized pin level equals the polarity bit. A clear write does not change it.
- R9: Masked status equals raw status ANDed with the enable register. irq is 1 exactly when any masked status bit is 1.
- R10: Writing the clear register clears the latched edge event of each pin whose bit is 1. Bits written 0 leave their pins untouched. The clear register reads as zero.
- R11: When a clear write and a new edge on the same pin land in the same cycle, the edge wins and raw status stays 1.
- R12: The configuration registers read back what was written. An unmapped offset reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset within the port |
| bus_wdata | input | 32 | Write data, bits [7:0] used |
| bus_rdata | output | 32 | Read data, same cycle |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| alt_out | input | 8 | Peripheral output values |
| alt_oe | input | 8 | Peripheral output enables |
| irq | output | 1 | Port interrupt |

## Verification
A wrong output register or a wrong data-window mask shows on pin_out at the clock edge after the write, before any read takes place. A wrong synchronizer depth or edge detector shows up in raw status. With correct logic, a rising or falling input appears in raw status two edges after the first sampling edge, so an extra or missing stage moves the event by a cycle. A wrong detector can also lose an edge or invent one. A latch that is cleared too eagerly shows up only when a clear write meets a new edge in the same cycle, so that case is driven with exact timing. A stuck enable or masked status is visible on irq in the same cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_DIR   = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_KIND  = 12'h404;
    localparam logic [ADDR_W-1:0] OFS_BOTH  = 12'h408;
    localparam logic [ADDR_W-1:0] OFS_POL   = 12'h40C;
    localparam logic [ADDR_W-1:0] OFS_IEN   = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MSK   = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 12'h41C;
    localparam logic [ADDR_W-1:0] OFS_ALT   = 12'h420;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_KIND,
        SEL_BOTH,
        SEL_POL,
        SEL_IEN,
        SEL_RAW,
        SEL_MSK,
        SEL_CLR,
        SEL_ALT
    } reg_sel_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            sync_out <= '0;
        end else begin
            meta_q   <= async_in;
            sync_out <= meta_q;
        end
    end

endmodule

// File: rtl/gpio_pin_irq.sv
module gpio_pin_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic kind_level,
    input  logic both_edges,
    input  logic polarity,
    input  logic clr,
    output logic raw
);

    logic prev_q;
    logic latch_q;
    logic rise;
    logic fall;
    logic evt;

    always_comb begin
        rise = level & ~prev_q;
        fall = ~level & prev_q;
        if (kind_level) begin
            evt = 1'b0;
        end else if (both_edges) begin
            evt = rise | fall;
        end else begin
            evt = polarity ? rise : fall;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q  <= level;
            latch_q <= (latch_q & ~clr) | evt;
        end
    end

    assign raw = kind_level ? (level == polarity) : latch_q;

    // R10: a clear without a coincident event empties the latch
    p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !latch_q);

    // R6: a latched edge persists until cleared
    p_latch_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !clr) |=> latch_q);

    // R8: the latch is only set while the pin is in edge mode
    p_set_only_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_q) |-> !$past(kind_level));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [PINS-1:0]   sync_in,
    input  logic [PINS-1:0]   raw_st,
    output logic [PINS-1:0]   data_q,
    output logic [PINS-1:0]   dir_q,
    output logic [PINS-1:0]   kind_q,
    output logic [PINS-1:0]   both_q,
    output logic [PINS-1:0]   pol_q,
    output logic [PINS-1:0]   ien_q,
    output logic [PINS-1:0]   alt_q,
    output logic [PINS-1:0]   clr_mask,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int unsigned MASK_LO = 2;
    localparam int unsigned MASK_HI = MASK_LO + PINS - 1;

    reg_sel_e        sel;
    logic            wr_en;
    logic [PINS-1:0] pin_mask;
    logic [PINS-1:0] wd;
    logic [PINS-1:0] sw_out;
    logic [PINS-1:0] pin_view;
    logic [PINS-1:0] rd;
    logic            unused_bits;

    assign unused_bits = ^{bus_wdata[DATA_W-1:PINS], bus_addr[MASK_LO-1:0]};

    always_comb begin
        if (bus_addr[ADDR_W-1:MASK_HI+1] == '0) begin
            sel = SEL_DATA;
        end else begin
            unique case (bus_addr)
                OFS_DIR:  sel = SEL_DIR;
                OFS_KIND: sel = SEL_KIND;
                OFS_BOTH: sel = SEL_BOTH;
                OFS_POL:  sel = SEL_POL;
                OFS_IEN:  sel = SEL_IEN;
                OFS_RAW:  sel = SEL_RAW;
                OFS_MSK:  sel = SEL_MSK;
                OFS_CLR:  sel = SEL_CLR;
                OFS_ALT:  sel = SEL_ALT;
                default:  sel = SEL_NONE;
            endcase
        end
    end

    assign wr_en    = bus_sel & bus_write;
    assign pin_mask = bus_addr[MASK_HI:MASK_LO];
    assign wd       = bus_wdata[PINS-1:0];
    assign clr_mask = (wr_en && sel == SEL_CLR) ? wd : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
            kind_q <= '0;
            both_q <= '0;
            pol_q  <= '0;
            ien_q  <= '0;
            alt_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DATA: data_q <= (data_q & ~pin_mask) | (wd & pin_mask);
                SEL_DIR:  dir_q  <= wd;
                SEL_KIND: kind_q <= wd;
                SEL_BOTH: both_q <= wd;
                SEL_POL:  pol_q  <= wd;
                SEL_IEN:  ien_q  <= wd;
                SEL_ALT:  alt_q  <= wd;
                default:  ;
            endcase
        end
    end

    assign sw_out   = dir_q & ~alt_q;
    assign pin_view = (sw_out & data_q) | (~sw_out & sync_in);

    always_comb begin
        unique case (sel)
            SEL_DATA: rd = pin_view & pin_mask;
            SEL_DIR:  rd = dir_q;
            SEL_KIND: rd = kind_q;
            SEL_BOTH: rd = both_q;
            SEL_POL:  rd = pol_q;
            SEL_IEN:  rd = ien_q;
            SEL_RAW:  rd = raw_st;
            SEL_MSK:  rd = raw_st & ien_q;
            SEL_ALT:  rd = alt_q;
            default:  rd = '0;
        endcase
    end

    assign bus_rdata = {{(DATA_W-PINS){1'b0}}, rd};

    // R2: pins outside the address mask keep their output value
    p_data_unmasked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA) |=>
            ((data_q & ~$past(pin_mask)) == ($past(data_q) & ~$past(pin_mask))));

    // R12: an unmapped write leaves every configuration register alone
    p_unmapped_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=>
            ($stable(dir_q) && $stable(ien_q) && $stable(alt_q) && $stable(data_q)));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    input  logic [PINS-1:0]   alt_out,
    input  logic [PINS-1:0]   alt_oe,
    output logic              irq
);

    logic [PINS-1:0] sync_in;
    logic [PINS-1:0] raw_st;
    logic [PINS-1:0] data_q, dir_q, kind_q, both_q, pol_q, ien_q, alt_q;
    logic [PINS-1:0] clr_mask;

    gpio_sync #(.W(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_in)
    );

    gpio_port_regs #(.PINS(PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .sync_in   (sync_in),
        .raw_st    (raw_st),
        .data_q    (data_q),
        .dir_q     (dir_q),
        .kind_q    (kind_q),
        .both_q    (both_q),
        .pol_q     (pol_q),
        .ien_q     (ien_q),
        .alt_q     (alt_q),
        .clr_mask  (clr_mask),
        .bus_rdata (bus_rdata)
    );

    for (genvar i = 0; i < PINS; i++) begin : g_pin
        gpio_pin_irq u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .level      (sync_in[i]),
            .kind_level (kind_q[i]),
            .both_edges (both_q[i]),
            .polarity   (pol_q[i]),
            .clr        (clr_mask[i]),
            .raw        (raw_st[i])
        );

        assign pin_out[i] = alt_q[i] ? alt_out[i] : data_q[i];
        assign pin_oe[i]  = alt_q[i] ? alt_oe[i]  : dir_q[i];
    end

    assign irq = |(raw_st & ien_q);

    // R9: the interrupt line needs at least one enabled pin
    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q != '0));

    // R4: a software-controlled pin drives only when set as output
    p_oe_follows_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((alt_q == '0) && (dir_q == '0)) |-> (pin_oe == '0));

endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic [7:0]  alt_out = '0;
    logic [7:0]  alt_oe = '0;
    logic        irq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .alt_out   (alt_out),
        .alt_oe    (alt_oe),
        .irq       (irq)
    );

    localparam logic [11:0] A_DIR = 12'h400, A_KIND = 12'h404, A_BOTH = 12'h408,
                            A_POL = 12'h40C, A_IEN = 12'h410, A_RAW = 12'h414,
                            A_MSK = 12'h418, A_CLR = 12'h41C, A_ALT = 12'h420;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = {24'hABCDE0, d} ;
        bus_wdata[31:8] = 24'h5A5A5A;
        @(negedge clk);
        bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        settle();
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        logic [7:0]  model;
        logic [11:0] cfg [7];
        cfg[0] = A_DIR; cfg[1] = A_KIND; cfg[2] = A_BOTH; cfg[3] = A_POL;
        cfg[4] = A_IEN; cfg[5] = A_ALT; cfg[6] = A_RAW;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 7; i++) begin
            rd(cfg[i], r);
            check("R1 reg reset", r, 32'h0);
        end
        rd(12'h0FC, r);
        check("R1 data reset", r, 32'h0);
        check("R1 pin_oe", {24'h0, pin_oe}, 32'h0);
        check("R1 pin_out", {24'h0, pin_out}, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        // R12 readback, unmapped offset; R10 clear reads zero
        for (int i = 0; i < 6; i++) begin
            logic [7:0] v;
            v = 8'(8'h3B * (i + 1) + 8'h11);
            wr(cfg[i], v);
            rd(cfg[i], r);
            check("R12 readback", r, {24'h0, v});
            wr(cfg[i], 8'h00);
        end
        wr(12'h600, 8'hFF);
        rd(12'h600, r);
        check("R12 unmapped read", r, 32'h0);
        rd(A_DIR, r);
        check("R12 unmapped write ignored", r, 32'h0);
        wr(A_CLR, 8'hFF);
        rd(A_CLR, r);
        check("R10 clear reads zero", r, 32'h0);

        // R2 masked data write sweep
        wr(A_DIR, 8'hFF);
        model = 8'h00;
        for (int m = 0; m < 256; m++) begin
            logic [7:0] v;
            v = 8'(m * 37 + 11);
            wr(12'(m << 2), v);
            model = (model & ~8'(m)) | (v & 8'(m));
            check("R2 masked write", {24'h0, pin_out}, {24'h0, model});
        end
        check("R4 all outputs", {24'h0, pin_oe}, 32'h0000_00FF);

        // R3 masked read sweep, R4 direction
        wr(A_DIR, 8'hF0);
        set_pins(8'h5A);
        check("R4 pin_oe", {24'h0, pin_oe}, 32'h0000_00F0);
        for (int m = 0; m < 256; m++) begin
            rd(12'(m << 2), r);
            check("R3 masked read", r, {24'h0, ((8'hF0 & model) | (8'h0F & 8'h5A)) & 8'(m)});
        end

        // R5 peripheral select
        alt_out = 8'hA5; alt_oe = 8'h0F;
        wr(A_ALT, 8'h3C);
        check("R5 pin_out", {24'h0, pin_out}, {24'h0, (8'h3C & 8'hA5) | (8'hC3 & model)});
        check("R5 pin_oe", {24'h0, pin_oe}, {24'h0, (8'h3C & 8'h0F) | (8'hC3 & 8'hF0)});
        wr(A_ALT, 8'h00);
        wr(A_DIR, 8'h00);
        set_pins(8'h00);
        wr(A_CLR, 8'hFF);

        // R6 single edge with polarity, per pin
        for (int p = 0; p < 8; p++) begin
            logic [7:0] b;
            b = 8'(1 << p);
            wr(A_POL, 8'hFF);
            set_pins(b);
            rd(A_RAW, r);
            check("R6 rising latched", r, {24'h0, b});
            set_pins(8'h00);
            rd(A_RAW, r);
            check("R6 latch holds", r, {24'h0, b});
            wr(A_CLR, b);
            wr(A_POL, 8'h00);
            set_pins(b);
            rd(A_RAW, r);
            check("R6 rise ignored when falling", r, 32'h0);
            set_pins(8'h00);
            rd(A_RAW, r);
            check("R6 falling latched", r, {24'h0, b});
            wr(A_CLR, 8'hFF);
        end

        // R7 both edges
        wr(A_BOTH, 8'h08);
        set_pins(8'h08);
        rd(A_RAW, r);
        check("R7 rise", r, 32'h08);
        wr(A_CLR, 8'h08);
        set_pins(8'h00);
        rd(A_RAW, r);
        check("R7 fall", r, 32'h08);
        wr(A_CLR, 8'hFF);
        wr(A_BOTH, 8'h00);

        // R8 level mode
        wr(A_KIND, 8'hFF);
        wr(A_POL, 8'h0F);
        set_pins(8'h33);
        rd(A_RAW, r);
        check("R8 level match", r, 32'hC3);
        wr(A_CLR, 8'hFF);
        rd(A_RAW, r);
        check("R8 not clearable", r, 32'hC3);
        set_pins(8'hFF);
        rd(A_RAW, r);
        check("R8 follows level", r, 32'h0F);

        // R9 masked status and irq
        wr(A_IEN, 8'h05);
        rd(A_MSK, r);
        check("R9 masked", r, 32'h05);
        check("R9 irq high", {31'h0, irq}, 32'h1);
        wr(A_IEN, 8'hF0);
        rd(A_MSK, r);
        check("R9 masked none", r, 32'h0);
        check("R9 irq low", {31'h0, irq}, 32'h0);
        wr(A_IEN, 8'h00);

        // R10 selective clear
        wr(A_KIND, 8'h00);
        wr(A_BOTH, 8'hFF);
        wr(A_CLR, 8'hFF);
        set_pins(8'h00);
        rd(A_RAW, r);
        check("R10 all latched", r, 32'hFF);
        wr(A_CLR, 8'h00);
        rd(A_RAW, r);
        check("R10 zero write no effect", r, 32'hFF);
        wr(A_CLR, 8'h0F);
        rd(A_RAW, r);
        check("R10 partial clear", r, 32'hF0);
        wr(A_CLR, 8'hFF);
        wr(A_BOTH, 8'h00);
        wr(A_POL, 8'hFF);

        // R11 clear and new edge in the same cycle
        @(negedge clk);
        pin_in = 8'h20;
        @(negedge clk);
        wr(A_CLR, 8'h20);
        settle();
        rd(A_RAW, r);
        check("R11 edge wins over clear", r, 32'h20);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule